// File: doc/BRIEF.md
# Bus Requester Front-End with Byte-Lane and Atomic Rules

This block sits between a simple local command port and a memory bus whose address channel uses a request/grant handshake and whose response channel uses valid/ready. A local client offers one command at a time through valid/ready. The command carries an address, a write flag, lane-positioned write data, an access size, a 6-bit atomic opcode and a transaction ID. The block turns each legal command into one address-phase request. It keeps that request on the bus, unchanged, until the bus grants it. It builds the byte enables from the size and the low address bits.

Some commands cannot be expressed as one legal bus access: a size and offset that would run past the word edge, or an atomic on an unaligned address. The block consumes such a command, flags it in the same cycle and issues nothing on the bus. It counts transactions from acceptance until their response is consumed, and stops taking commands at a fixed limit. After an atomic it stops taking commands until every outstanding response has come back. The response channel passes straight through to the local side, so the local client alone decides when to take a response.

Top module: `obi_req_frontend`

## Requirements
- R1: Once `req` is high it stays high in every following cycle until a cycle in which `gnt` is also high. The address handshake is the cycle with both `req` and `gnt` high.
- R2: While `req` is high and `gnt` is low, `addr`, `we`, `be`, `wdata`, `aid`, `atop`, `memtype` and `prot` keep their values into the next cycle.
- R3: The byte enables are set bits at lane positions offset through offset+n-1, where the offset is `addr[1:0]`. The size encodings are 0 = byte, 1 = halfword and 2 = word, giving n = 1, 2 and 4. For example, a halfword at offset 1 gives `be` = 4'b0110. A driven `be` is never zero, its set bits are one contiguous run, and it has no bit set below the address offset.
- R4: A command with size 3, or whose size and offset would pass lane 3, is accepted with `cmd_err` high in its handshake cycle. It raises no request and takes no slot of the outstanding limit.
- R5: A command with a nonzero `cmd_atop` and a nonzero `cmd_addr[1:0]` is rejected in the same way as in R4. Any `atop` driven on the bus with `req` high has `addr[1:0]` = 0.
- R6: After an atomic command (nonzero `cmd_atop`) is accepted, `cmd_ready` stays low until the responses of all accepted transactions, the atomic included, have been consumed. No request follows a granted atomic until then.
- R7: At most 4 accepted transactions are outstanding. With 4 outstanding, `cmd_ready` is low until a response is consumed.
- R8: `rready` equals `rsp_ready` in every cycle, whatever `rvalid` is. `rsp_valid`, `rsp_rdata`, `rsp_err`, `rsp_id` and `rsp_exokay` mirror the bus response. A response is consumed only in a cycle where `rvalid` and `rready` are both high.
- R9: After reset `req` is low and `cmd_ready` is high.
- R10: A legal command accepted at a clock edge is on the bus from that edge on. `addr` and `wdata` equal the command's values, `we` equals the write flag, `aid` equals the ID and `atop` equals the opcode. `memtype` and `prot` carry the values set by the parameters. `req` falls after the grant edge unless a new command was accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Local command offered |
| cmd_ready | output | 1 | Local command can be taken this cycle |
| cmd_addr | input | 32 | Byte address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Write data, already placed on its byte lanes |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cmd_atop | input | 6 | Atomic opcode, zero for a plain access |
| cmd_id | input | 4 | Transaction ID |
| cmd_err | output | 1 | Offered command is illegal and is dropped when taken |
| req | output | 1 | Address-phase request |
| gnt | input | 1 | Address-phase grant |
| addr | output | 32 | Request address |
| we | output | 1 | Request write enable |
| be | output | 4 | Request byte enables |
| wdata | output | 32 | Request write data |
| aid | output | 4 | Request ID |
| atop | output | 6 | Request atomic opcode |
| memtype | output | 2 | Memory attribute bits (parameter) |
| prot | output | 3 | Protection bits (parameter) |
| rvalid | input | 1 | Bus response valid |
| rready | output | 1 | Bus response ready |
| rdata | input | 32 | Bus response data |
| err | input | 1 | Bus response error |
| rid | input | 4 | Bus response ID |
| exokay | input | 1 | Bus exclusive-okay flag |
| rsp_valid | output | 1 | Local response valid |
| rsp_ready | input | 1 | Local response ready |
| rsp_rdata | output | 32 | Local response data |
| rsp_err | output | 1 | Local response error |
| rsp_id | output | 4 | Local response ID |
| rsp_exokay | output | 1 | Local exclusive-okay flag |

## Verification
The assertions take for granted that the bus never returns a response while no transaction is outstanding. They also assume the response ordering follows acceptance order, so the last response to drain belongs to the atomic. The stimulus respects this by sending exactly one response per accepted legal command, in acceptance order, and never one for a rejected command. Grant is raised only while a request is pending, after zero to several wait cycles. Some responses are held back with `rsp_ready` low, and in other cycles `rsp_ready` is raised with no response present.

// File: rtl/obi_fe_pkg.sv
// Shared types for the bus requester front-end.
// Assumes a size field of two bits, with encodings fixed below.
package obi_fe_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/obi_fe_lane_map.sv
// Lane mapper: turns an access size and byte offset into byte enables and
// flags a command that cannot be one legal bus access. The access is illegal
// when it runs past the top lane or its size exceeds the bus, or when it is
// atomic and not aligned to the bus width. Purely combinational.
module obi_fe_lane_map #(
    parameter int NB = 4
) (
    input  logic [$clog2(NB)-1:0] off,
    input  logic [1:0]            size,
    input  logic                  atomic,
    output logic [NB-1:0]         be,
    output logic                  bad
);
    localparam int OFFW = $clog2(NB);

    // Build the lane mask and decide legality.
    always_comb begin
        int span;
        int base;
        logic fits;
        span = 1 << size;
        base = int'(off);
        fits = (int'(size) <= OFFW) && (base + span <= NB);
        bad  = !fits || (atomic && (off != '0));
        for (int i = 0; i < NB; i++) begin
            be[i] = fits && (i >= base) && (i < base + span);
        end
    end
endmodule

// File: rtl/obi_fe_addr_stage.sv
// Address-phase holding register. Loads a request when told to and keeps
// every field steady until the grant. Assumes the caller loads only when
// no request is pending or the pending one is granted in that cycle.
module obi_fe_addr_stage #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int IDW = 4,
    parameter int OPW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             gnt,
    input  logic [AW-1:0]    in_addr,
    input  logic             in_we,
    input  logic [DW/8-1:0]  in_be,
    input  logic [DW-1:0]    in_wdata,
    input  logic [IDW-1:0]   in_id,
    input  logic [OPW-1:0]   in_atop,
    output logic             req,
    output logic [AW-1:0]    addr,
    output logic             we,
    output logic [DW/8-1:0]  be,
    output logic [DW-1:0]    wdata,
    output logic [IDW-1:0]   aid,
    output logic [OPW-1:0]   atop
);
    // Pending flag: set on load, cleared by the grant.
    always_ff @(posedge clk) begin
        if (!rst_n)    req <= 1'b0;
        else if (load) req <= 1'b1;
        else if (gnt)  req <= 1'b0;
    end

    // Field registers: change only when a new request is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            we    <= 1'b0;
            be    <= '0;
            wdata <= '0;
            aid   <= '0;
            atop  <= '0;
        end else if (load) begin
            addr  <= in_addr;
            we    <= in_we;
            be    <= in_be;
            wdata <= in_wdata;
            aid   <= in_id;
            atop  <= in_atop;
        end
    end

    // R1: a request waiting for grant is not withdrawn
    a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req && !gnt |=> req);

    // R2: address-phase fields hold while waiting for grant
    a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req && !gnt |=> $stable(addr) && $stable(we) && $stable(be)
                        && $stable(wdata) && $stable(aid) && $stable(atop));
endmodule

// File: rtl/obi_fe_outstanding.sv
// Outstanding-transaction tracker. Counts accepted transactions until their
// response is consumed and reports whether another may be taken. Remembers
// that an atomic is in flight until the count drains to zero. Assumes
// responses arrive in acceptance order and never exceed accepted ones.
module obi_fe_outstanding #(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic inc_atomic,
    input  logic dec,
    output logic room,
    output logic atom_busy
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [CW-1:0] cnt_q;

    // Up/down count of transactions between acceptance and response.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
        else if (!inc && dec) cnt_q <= cnt_q - 1'b1;
    end

    // Atomic-in-flight flag: set on atomic acceptance, cleared at drain.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     atom_busy <= 1'b0;
        else if (inc && inc_atomic)                     atom_busy <= 1'b1;
        else if (dec && !inc && cnt_q == CW'(1))        atom_busy <= 1'b0;
    end

    assign room = (cnt_q < CW'(MAX_OUT));

    // R7: the count never passes its limit
    a_r7_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_OUT));

    // R7: nothing is accepted while the limit is reached
    a_r7_no_inc_full: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CW'(MAX_OUT) |-> !inc);
endmodule

// File: rtl/obi_req_frontend.sv
// Bus requester front-end. Accepts local commands over valid/ready, rejects
// those that cannot be one legal access, and places legal ones into the
// address-phase register. Limits transactions in flight and stalls behind
// atomics. The response channel is a straight pass-through. Assumes one
// response per accepted legal command, returned in order.
module obi_req_frontend #(
    parameter int         AW      = 32,
    parameter int         DW      = 32,
    parameter int         IDW     = 4,
    parameter int         MAX_OUT = 4,
    parameter logic [1:0] MEMTYPE = 2'b00,
    parameter logic [2:0] PROT    = 3'b111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             cmd_write,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [1:0]       cmd_size,
    input  logic [5:0]       cmd_atop,
    input  logic [IDW-1:0]   cmd_id,
    output logic             cmd_err,
    output logic             req,
    input  logic             gnt,
    output logic [AW-1:0]    addr,
    output logic             we,
    output logic [DW/8-1:0]  be,
    output logic [DW-1:0]    wdata,
    output logic [IDW-1:0]   aid,
    output logic [5:0]       atop,
    output logic [1:0]       memtype,
    output logic [2:0]       prot,
    input  logic             rvalid,
    output logic             rready,
    input  logic [DW-1:0]    rdata,
    input  logic             err,
    input  logic [IDW-1:0]   rid,
    input  logic             exokay,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_err,
    output logic [IDW-1:0]   rsp_id,
    output logic             rsp_exokay
);
    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);

    logic [NB-1:0] cmd_be;
    logic          cmd_bad;
    logic          room;
    logic          atom_busy;
    logic          accept;
    logic          issue;
    logic          is_atomic;
    logic          rsp_hs;

    assign is_atomic = (cmd_atop != '0);

    obi_fe_lane_map #(.NB(NB)) u_lane_map (
        .off    (cmd_addr[OFFW-1:0]),
        .size   (cmd_size),
        .atomic (is_atomic),
        .be     (cmd_be),
        .bad    (cmd_bad)
    );

    // Handshake decode: take a command when the slot frees and limits allow.
    always_comb begin
        cmd_ready = (!req || gnt) && room && !atom_busy;
        accept    = cmd_valid && cmd_ready;
        issue     = accept && !cmd_bad;
        cmd_err   = cmd_valid && cmd_bad;
        rsp_hs    = rvalid && rready;
    end

    obi_fe_addr_stage #(.AW(AW), .DW(DW), .IDW(IDW), .OPW(6)) u_addr_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .gnt      (gnt),
        .in_addr  (cmd_addr),
        .in_we    (cmd_write),
        .in_be    (cmd_be),
        .in_wdata (cmd_wdata),
        .in_id    (cmd_id),
        .in_atop  (cmd_atop),
        .req      (req),
        .addr     (addr),
        .we       (we),
        .be       (be),
        .wdata    (wdata),
        .aid      (aid),
        .atop     (atop)
    );

    obi_fe_outstanding #(.MAX_OUT(MAX_OUT)) u_outstanding (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (issue),
        .inc_atomic (is_atomic),
        .dec        (rsp_hs),
        .room       (room),
        .atom_busy  (atom_busy)
    );

    // Constant attributes and response pass-through.
    always_comb begin
        memtype    = MEMTYPE;
        prot       = PROT;
        rready     = rsp_ready;
        rsp_valid  = rvalid;
        rsp_rdata  = rdata;
        rsp_err    = err;
        rsp_id     = rid;
        rsp_exokay = exokay;
    end

    // Shape checks on the driven byte enables (lowest-set-bit arithmetic).
    logic [NB-1:0] be_low;
    logic [NB-1:0] be_sum;
    logic [NB-1:0] off_mask;
    always_comb begin
        be_low   = be & (~be + 1'b1);
        be_sum   = be + be_low;
        off_mask = NB'((1 << addr[OFFW-1:0]) - 1);
    end

    // R3: enables on the bus are nonzero and one contiguous run
    a_r3_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (be != '0) && ((be_sum & be) == '0));

    // R3: no enabled lane below the address offset
    a_r3_be_offset: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (be & off_mask) == '0);

    // R5: atomics on the bus are aligned to the bus width
    a_r5_atomic_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req && (atop != '0) |-> addr[OFFW-1:0] == '0);

    // R6: a granted atomic is not followed by another request at once
    a_r6_atomic_alone: assert property (@(posedge clk) disable iff (!rst_n)
        req && gnt && (atop != '0) |=> !req);

    // R4: a rejected command never loads the address stage
    a_r4_reject_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_bad && !(req && !gnt) |=> !req);
endmodule

// File: tb/obi_req_frontend_bench.sv
module obi_req_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [1:0]  cmd_size = '0;
    logic [5:0]  cmd_atop = '0;
    logic [3:0]  cmd_id = '0;
    logic        cmd_err;
    logic        req;
    logic        gnt = 1'b0;
    logic [31:0] addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [3:0]  aid;
    logic [5:0]  atop;
    logic [1:0]  memtype;
    logic [2:0]  prot;
    logic        rvalid = 1'b0;
    logic        rready;
    logic [31:0] rdata = '0;
    logic        err = 1'b0;
    logic [3:0]  rid = '0;
    logic        exokay = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [3:0]  rsp_id;
    logic        rsp_exokay;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    obi_req_frontend u_obi_req_frontend (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
        .cmd_atop(cmd_atop), .cmd_id(cmd_id), .cmd_err(cmd_err),
        .req(req), .gnt(gnt), .addr(addr), .we(we), .be(be), .wdata(wdata),
        .aid(aid), .atop(atop), .memtype(memtype), .prot(prot),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .err(err),
        .rid(rid), .exokay(exokay),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_id(rsp_id), .rsp_exokay(rsp_exokay)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [1:0] sz);
        logic [3:0] lanes;
        lanes = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
        return lanes << off;
    endfunction

    // One legal command, granted after wait_gnt stall cycles.
    task automatic issue(input logic [31:0] a, input logic wr, input logic [31:0] d,
                         input logic [1:0] sz, input logic [5:0] op,
                         input logic [3:0] id, input int wait_gnt);
        logic [3:0] eb;
        eb = exp_be(a[1:0], sz);
        cmd_addr = a; cmd_write = wr; cmd_wdata = d; cmd_size = sz;
        cmd_atop = op; cmd_id = id; cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, "R10 ready", {63'd0, cmd_ready}, 64'd1);
        chk(cmd_err == 1'b0, "R4 no err on legal", {63'd0, cmd_err}, 64'd0);
        cyc();
        cmd_valid = 1'b0;
        #1;
        chk(req == 1'b1, "R10 req", {63'd0, req}, 64'd1);
        chk(addr == a, "R10 addr", {32'd0, addr}, {32'd0, a});
        chk(we == wr && aid == id && atop == op, "R10 we/aid/atop",
            {53'd0, we, aid, atop}, {53'd0, wr, id, op});
        chk(wdata == d, "R10 wdata", {32'd0, wdata}, {32'd0, d});
        chk(memtype == 2'b00 && prot == 3'b111, "R10 attrs",
            {59'd0, memtype, prot}, {59'd0, 2'b00, 3'b111});
        chk(be == eb, "R3 be", {60'd0, be}, {60'd0, eb});
        for (int i = 0; i < wait_gnt; i++) begin
            cyc();
            #1;
            chk(req == 1'b1, "R1 req held", {63'd0, req}, 64'd1);
            chk(addr == a && be == eb && aid == id, "R2 stable",
                {28'd0, addr, be}, {28'd0, a, eb});
        end
        gnt = 1'b1;
        cyc();
        gnt = 1'b0;
        #1;
        chk(req == 1'b0, "R10 req drops after grant", {63'd0, req}, 64'd0);
    endtask

    // One illegal command: taken with cmd_err, no request follows.
    task automatic reject(input logic [31:0] a, input logic [1:0] sz,
                          input logic [5:0] op, input string rq);
        cmd_addr = a; cmd_size = sz; cmd_atop = op; cmd_write = 1'b1;
        cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, {rq, " ready"}, {63'd0, cmd_ready}, 64'd1);
        chk(cmd_err == 1'b1, {rq, " err"}, {63'd0, cmd_err}, 64'd1);
        cyc();
        cmd_valid = 1'b0;
        cmd_atop = '0;
        #1;
        chk(req == 1'b0, {rq, " no req"}, {63'd0, req}, 64'd0);
    endtask

    // One response, held one cycle with rsp_ready low, then consumed.
    task automatic respond(input logic [3:0] id, input logic [31:0] d,
                           input logic e, input logic xo);
        rvalid = 1'b1; rid = id; rdata = d; err = e; exokay = xo;
        rsp_ready = 1'b0;
        #1;
        chk(rsp_valid == 1'b1 && rready == 1'b0, "R8 held",
            {62'd0, rsp_valid, rready}, 64'd2);
        cyc();
        rsp_ready = 1'b1;
        #1;
        chk(rready == 1'b1, "R8 rready", {63'd0, rready}, 64'd1);
        chk(rsp_rdata == d && rsp_id == id && rsp_err == e && rsp_exokay == xo,
            "R8 fields", {26'd0, rsp_rdata, rsp_id, rsp_err, rsp_exokay},
            {26'd0, d, id, e, xo});
        cyc();
        rvalid = 1'b0; rsp_ready = 1'b0; exokay = 1'b0; err = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(req == 1'b0, "R9 req", {63'd0, req}, 64'd0);
        chk(cmd_ready == 1'b1, "R9 ready", {63'd0, cmd_ready}, 64'd1);
    endtask

    task automatic t_lanes();
        issue(32'h1000, 1'b1, 32'h0000_00AA, 2'd0, 6'd0, 4'd1, 0);
        respond(4'd1, 32'h0, 1'b0, 1'b0);
        issue(32'h1003, 1'b1, 32'hBB00_0000, 2'd0, 6'd0, 4'd2, 2);
        respond(4'd2, 32'h0, 1'b0, 1'b0);
        issue(32'h1001, 1'b0, 32'h0, 2'd1, 6'd0, 4'd3, 1);
        respond(4'd3, 32'h00CC_DD00, 1'b0, 1'b0);
        issue(32'h1002, 1'b1, 32'h1234_0000, 2'd1, 6'd0, 4'd4, 3);
        respond(4'd4, 32'h0, 1'b1, 1'b0);
        issue(32'h2000, 1'b0, 32'h0, 2'd2, 6'd0, 4'd5, 0);
        respond(4'd5, 32'hDEAD_BEEF, 1'b0, 1'b0);
    endtask

    task automatic t_rejects();
        reject(32'h3003, 2'd1, 6'd0, "R4 half over edge");
        reject(32'h3002, 2'd2, 6'd0, "R4 word unaligned");
        reject(32'h3000, 2'd3, 6'd0, "R4 reserved size");
        reject(32'h3002, 2'd0, 6'h12, "R5 atomic unaligned");
    endtask

    task automatic t_limit();
        for (int k = 0; k < 4; k++) begin
            issue(32'h4000 + 32'(k * 4), 1'b0, 32'h0, 2'd2, 6'd0, 4'(k), 0);
        end
        cmd_addr = 32'h4040; cmd_size = 2'd2; cmd_atop = '0; cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b0, "R7 full", {63'd0, cmd_ready}, 64'd0);
        rsp_ready = 1'b1;
        cyc();
        #1;
        chk(cmd_ready == 1'b0, "R8 no consume without rvalid",
            {63'd0, cmd_ready}, 64'd0);
        chk(rready == 1'b1, "R8 rready without rvalid", {63'd0, rready}, 64'd1);
        cmd_valid = 1'b0;
        respond(4'd0, 32'h0, 1'b0, 1'b0);
        #1;
        chk(cmd_ready == 1'b1, "R7 slot freed", {63'd0, cmd_ready}, 64'd1);
        for (int k = 1; k < 4; k++) begin
            respond(4'(k), 32'h0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_atomic();
        issue(32'h5000, 1'b1, 32'h55, 2'd2, 6'h13, 4'd7, 1);
        #1;
        chk(cmd_ready == 1'b0, "R6 stall after atomic", {63'd0, cmd_ready}, 64'd0);
        cyc();
        #1;
        chk(req == 1'b0, "R6 no req", {63'd0, req}, 64'd0);
        respond(4'd7, 32'h0, 1'b0, 1'b1);
        #1;
        chk(cmd_ready == 1'b1, "R6 released", {63'd0, cmd_ready}, 64'd1);
        issue(32'h6000, 1'b0, 32'h0, 2'd0, 6'd0, 4'd8, 0);
        issue(32'h6004, 1'b0, 32'h0, 2'd2, 6'h12, 4'd9, 0);
        respond(4'd8, 32'h11, 1'b0, 1'b0);
        #1;
        chk(cmd_ready == 1'b0, "R6 still busy", {63'd0, cmd_ready}, 64'd0);
        respond(4'd9, 32'h22, 1'b0, 1'b1);
        #1;
        chk(cmd_ready == 1'b1, "R6 drained", {63'd0, cmd_ready}, 64'd1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_rejects();
        t_limit();
        t_atomic();
        cyc();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule